// File: doc/BRIEF.md
# Addressed Configuration Register Slave over SPI

This block is a serial slave that fills a bank of sixteen 12-bit configuration registers from 16-bit serial frames. The frame's leading four bits select the register. The trailing twelve bits are the value to store. Both fields arrive most significant bit first. While the master clocks in a frame, the block clocks out a 16-bit status word. It samples that word from a parallel input when chip select falls. The low byte of the word carries a coarse signal-strength range.

All serial inputs are brought into the system clock domain through two-stage synchronizers, and every edge is detected there. The serial clock must therefore be several times slower than the system clock. A frame is accepted only if exactly sixteen serial clock rising edges were seen while chip select was low. The write takes effect after chip select returns high. Any other frame length leaves the bank untouched.

Top module: `spi_regfile`

## Requirements
- R1: After reset every register output reads 0 and `spi_miso_o` is 0.
- R2: A frame of exactly 16 SCK rising edges writes frame bits 11..0 into the register selected by frame bits 15..12. Bit 15 is sent first and is address bit 3. Bit 0 is sent last and is data bit 0. Register n appears on `regs_o[n*12 +: 12]`.
- R3: A write changes only the addressed register. All 16 addresses, 0 to 15, are writable.
- R4: A frame with fewer than 16 SCK rising edges, including none, changes no register.
- R5: A frame with more than 16 SCK rising edges changes no register.
- R6: `status_i` is captured when NSS falls and is shifted out on MISO, bit 15 first. Each SCK falling edge presents the next bit. Changes on `status_i` after capture do not alter the word being sent.
- R7: SCK edges while NSS is high are ignored. They shift nothing out on MISO and write nothing.
- R8: No register changes while NSS is still low, even after the 16th SCK edge. The update follows the NSS rising edge by a few system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_nss_i | input | 1 | Chip select, active low, one low period per frame |
| spi_sck_i | input | 1 | Serial clock; MOSI sampled on rising edge |
| spi_mosi_i | input | 1 | Serial data in, MSB first |
| spi_miso_o | output | 1 | Serial status data out, changes after SCK falling edge |
| status_i | input | 16 | Status word; low 8 bits are signal-strength range |
| regs_o | output | 192 | Sixteen 12-bit registers, register n at bits n*12 +: 12 |

## Verification
Directed frames write a distinct value to each of the sixteen addresses. This separates address decoding and bit ordering faults, such as a swapped field or a reversed shift. Frames of 0, 4, 15 and 17 clocks are interleaved with valid ones, which exposes a length check that is off by one or missing. Serial clock toggling with chip select high, after a partial frame has left a known MISO bit, shows whether idle edges leak into the shifter. Random frames with random lengths and random status words, some with the status input changed mid-frame, exercise the capture point of the read word against a bench register model.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;
  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned DATA_W_DEF = 12;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned frame_w);
    return $clog2(frame_w) + 2;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import spi_regfile_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [SYNC_STAGES-1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {SYNC_STAGES{RST_VAL[b]}};
      else         stg_q <= {stg_q[SYNC_STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = stg_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nss_i,
  input  logic               sck_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o,
  output logic               miso_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               nss_q, sck_q;
  logic               nss_fall, nss_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_sr, tx_sr;

  assign nss_fall = nss_q & ~nss_i;
  assign nss_rise = ~nss_q & nss_i;
  assign sck_rise = ~sck_q & sck_i & ~nss_i;
  assign sck_fall = sck_q & ~sck_i & ~nss_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nss_q    <= 1'b1;
      sck_q    <= 1'b0;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      frame_o  <= '0;
      commit_o <= 1'b0;
    end else begin
      nss_q    <= nss_i;
      sck_q    <= sck_i;
      commit_o <= nss_rise && (bit_cnt == FULL);
      if (nss_rise) frame_o <= rx_sr;
      if (nss_fall) begin
        bit_cnt <= '0;
        tx_sr   <= status_i;
      end else begin
        if (sck_rise) begin
          rx_sr <= {rx_sr[FRAME_W-2:0], mosi_i};
          if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;  // saturate, never wraps back to FULL
        end
        if (sck_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_sr[FRAME_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned NREG  = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  val_q <= '0;
      else if (we_i && (addr_i == ADDR_W'(r)))      val_q <= data_i;
    end
    assign regs_o[r*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  localparam int unsigned FRAME_W = ADDR_W + DATA_W,
  localparam int unsigned NREG    = 1 << ADDR_W,
  localparam int unsigned CNT_W   = cnt_width(FRAME_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   spi_nss_i,
  input  logic                   spi_sck_i,
  input  logic                   spi_mosi_i,
  output logic                   spi_miso_o,
  input  logic [FRAME_W-1:0]     status_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic               nss_s, sck_s, mosi_s;
  logic [FRAME_W-1:0] frame;
  logic               commit;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({spi_nss_i, spi_sck_i, spi_mosi_i}),
    .q_o({nss_s, sck_s, mosi_s})
  );

  spi_frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni,
    .nss_i(nss_s), .sck_i(sck_s), .mosi_i(mosi_s),
    .status_i,
    .frame_o(frame), .commit_o(commit), .miso_o(spi_miso_o)
  );

  spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i(commit),
    .addr_i(frame[FRAME_W-1 -: ADDR_W]),
    .data_i(frame[DATA_W-1:0]),
    .regs_o
  );
endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned NREG  = 1 << ADDR_W,
  localparam int unsigned FRAME_W = ADDR_W + DATA_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   nss_s,
  input logic                   sck_s,
  input logic                   commit,
  input logic                   miso,
  input logic [NREG*DATA_W-1:0] regs
);
  logic                   nss_p, sck_p;
  logic [7:0]             edges;
  logic [NREG*DATA_W-1:0] regs_p;
  logic [NREG-1:0]        changed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nss_p  <= 1'b1;
      sck_p  <= 1'b0;
      edges  <= '0;
      regs_p <= '0;
    end else begin
      nss_p  <= nss_s;
      sck_p  <= sck_s;
      regs_p <= regs;
      if (nss_p && !nss_s)                         edges <= '0;
      else if (!sck_p && sck_s && !nss_s && edges != 8'hff) edges <= edges + 8'd1;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    assign changed[r] = regs[r*DATA_W +: DATA_W] != regs_p[r*DATA_W +: DATA_W];
  end

  // R2 R4 R5: a commit only follows a chip-select release after exactly FRAME_W edges
  p_exact_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> ($past(edges) == 8'(FRAME_W)) && $past(nss_s && !nss_p));

  // R8: bank changes only on a commit
  p_write_on_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (changed != '0) |-> $past(commit));

  // R3: at most one register changes at a time
  p_one_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(changed) <= 1);

  // R6: MISO moves only after a selected SCK fall or a select fall
  p_miso_edges_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso != $past(miso)) |-> $past((sck_p && !sck_s && !nss_s) || (nss_p && !nss_s)));

  // R7: MISO holds while deselected
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nss_s && nss_p) |=> $stable(miso));
endmodule

bind spi_regfile spi_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .nss_s, .sck_s, .commit, .miso(spi_miso_o), .regs(regs_o)
);

// File: tb/sim_spi_regfile.sv
module sim_spi_regfile;
  localparam int NREG = 16;
  localparam int DW   = 12;
  localparam int HALF = 6;

  logic clk_i = 0, rst_ni = 0;
  logic spi_nss_i = 1, spi_sck_i = 0, spi_mosi_i = 0;
  logic spi_miso_o;
  logic [15:0] status_i = '0;
  logic [NREG*DW-1:0] regs_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] model [NREG];

  always #10 clk_i = ~clk_i;

  spi_regfile u0 (.*);

  function automatic logic [NREG*DW-1:0] flat();
    logic [NREG*DW-1:0] f;
    for (int r = 0; r < NREG; r++) f[r*DW +: DW] = model[r];
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NREG*DW-1:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic xfer(input logic [15:0] w, input int nclk, input logic [15:0] st,
                      input bit swap, input string req);
    logic [15:0] rd;
    rd = '0;
    status_i = st;
    spi_nss_i = 0;
    wclk(8);
    if (swap) status_i = ~st;
    for (int i = 0; i < nclk; i++) begin
      spi_mosi_i = (i < 16) ? w[15-i] : 1'($urandom);
      wclk(HALF);
      if (i < 16) rd[15-i] = spi_miso_o;
      spi_sck_i = 1;
      wclk(HALF);
      spi_sck_i = 0;
    end
    wclk(10);
    check(regs_o == flat(), "R8", regs_o, flat());
    spi_nss_i = 1;
    wclk(8);
    if (nclk == 16) model[w[15:12]] = w[11:0];
    check(regs_o == flat(), req, regs_o, flat());
    if (nclk >= 16) check(rd == st, "R6", {176'd0, rd}, {176'd0, st});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < NREG; r++) model[r] = '0;
    wclk(4);
    rst_ni = 1;
    wclk(4);
    check(regs_o == '0, "R1", regs_o, '0);
    check(spi_miso_o == 0, "R1", {191'd0, spi_miso_o}, '0);

    // R2 R3: every address, distinct values, including test registers 14 and 15
    for (int a = 0; a < NREG; a++)
      xfer({4'(a), 12'(12'h9A0 ^ (a * 12'h111))}, 16, 16'hA5C3 ^ 16'(a), 0, "R2");
    xfer(16'hF123, 16, 16'h00FF, 0, "R3");
    xfer(16'hE456, 16, 16'hFF00, 0, "R3");

    // R4: short and empty frames
    xfer(16'h3FFF, 15, 16'h1234, 0, "R4");
    xfer(16'h4ABC, 0,  16'h1234, 0, "R4");
    xfer(16'h5ABC, 4,  16'h1234, 0, "R4");
    // R5: long frame
    xfer(16'h6777, 17, 16'h8001, 0, "R5");
    // R6: status changed after capture
    xfer(16'h7321, 16, 16'hC35A, 1, "R6");

    // R7: leave miso=1 after a 4-edge frame, then toggle SCK while deselected
    xfer(16'h0000, 4, 16'hFFFF, 0, "R4");
    for (int i = 0; i < 20; i++) begin
      spi_mosi_i = 1'($urandom);
      spi_sck_i = 1; wclk(HALF);
      spi_sck_i = 0; wclk(HALF);
    end
    wclk(6);
    check(spi_miso_o == 1, "R7", {191'd0, spi_miso_o}, 192'd1);
    check(regs_o == flat(), "R7", regs_o, flat());
    xfer(16'h2ACE, 16, 16'h0F0F, 0, "R7");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int pick, len;
      pick = int'($urandom_range(0, 9));
      len = (pick < 6) ? 16 : (pick == 6) ? 15 : (pick == 7) ? 17 : int'($urandom_range(0, 20));
      xfer(16'($urandom), len, 16'($urandom), 1'($urandom), (len == 16) ? "R2" : (len < 16) ? "R4" : "R5");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule